// File: doc/BRIEF.md
# Assist Routine Trigger Scheduler

This block decides, cycle by cycle, who owns a single instruction issue slot: the main instruction stream or one of the helper routines kept in a small on-chip routine store. Helper routines are loaded through a write port. Each store word is addressed by a routine number and a step index, and carries an end mark. A load whose per-block metadata flag says the block is compressed queues an urgent unpack routine. That routine is released only when the matching data-arrival strobe has been seen. A store queues an optional pack routine that only fills slots the main stream leaves unused.

Urgent routines take the slot from the main stream until their final step has issued. Optional work is fragile. A queued optional routine is discarded when an urgent request is accepted before it starts. A running optional routine is abandoned when an urgent routine begins. Every issue decision is registered, so it appears at the outputs one cycle after the inputs that caused it.

Top module: `assist_sched`

## Requirements
- R1: A word written with `prog_we` at routine `prog_rid`, step `prog_idx` is the word presented on `iss_instr` when that routine reaches that step. Steps issue in order from 0. A routine ends at the first step written with `prog_last`=1, or at step ROUTINE_LEN-1.
- R2: A load with `ld_valid`=1, `ld_cmp`=1 and `ld_ready`=1 queues an urgent routine `ld_rid`. It starts only after a `data_arr` strobe has been credited to it. Strobes are credited to queued loads oldest first, and strobes beyond the number of queued loads are ignored.
- R3: A load with `ld_cmp`=0 triggers no routine.
- R4: From the first to the final step of an urgent routine, the main stream is never given the slot (`iss_sel`=1 never appears). Each granted cycle issues the next urgent step (`iss_sel`=2).
- R5: A store (`st_valid`=1) makes routine `st_rid` pending at low priority. It starts only when no urgent routine is running or queued. Its steps issue (`iss_sel`=3) only in granted cycles in which `main_req` was 0.
- R6: A pending low-priority routine that has not started is discarded when an urgent request is accepted. A store in that same cycle is discarded too.
- R7: A running low-priority routine is abandoned when an urgent routine starts. The step issued in that cycle is its last, and it reports no completion.
- R8: At most HQ_DEPTH urgent requests wait at once. `ld_ready` is 0 while the queue is full, and a load offered then has no effect.
- R9: `done_valid` is 1 exactly in the cycle the final step of a completed routine is presented. At that point `done_hp`=1 for urgent and 0 for optional, and `done_rid` names the routine.
- R10: In a cycle after `slot_gnt` was 0, `iss_sel` is 0 (idle) and no routine advances.
- R11: `iss_sel` encodes 0 idle, 1 main stream, 2 urgent step, 3 optional step. It reflects the inputs of the previous clock edge.
- R12: During and right after reset, `iss_sel`=0, `done_valid`=0 and `ld_ready`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| prog_we | input | 1 | Write one routine-store word |
| prog_rid | input | RID_W | Routine number of the write |
| prog_idx | input | IDX_W | Step index of the write |
| prog_instr | input | INSTR_W | Instruction word written |
| prog_last | input | 1 | End mark of the written step |
| ld_valid | input | 1 | Load event |
| ld_cmp | input | 1 | Metadata flag: block stored compressed |
| ld_rid | input | RID_W | Unpack routine for this load |
| ld_ready | output | 1 | Urgent queue can take a load |
| st_valid | input | 1 | Store event |
| st_rid | input | RID_W | Pack routine for this store |
| data_arr | input | 1 | Load data has arrived (oldest pending load) |
| main_req | input | 1 | Main stream wants the slot |
| slot_gnt | input | 1 | Issue slot available this cycle |
| iss_sel | output | 2 | Slot owner: 0 idle, 1 main, 2 urgent, 3 optional |
| iss_rid | output | RID_W | Routine of the issued step |
| iss_instr | output | INSTR_W | Issued routine instruction |
| done_valid | output | 1 | Final step of a routine issued |
| done_hp | output | 1 | Completed routine was urgent |
| done_rid | output | RID_W | Completed routine number |

## Verification
Two events can coincide. An urgent request can be accepted in the same cycle as a store, and an urgent routine can start in the same cycle as an optional routine issues a step. The bench drives a store and a compressed load on one edge. It also times a load and its arrival strobe so that the urgent start lands exactly five steps into a running optional routine. A scoreboard holds every expected step and completion and flags any extra, missing or reordered one. So the discarded store must leave no optional step behind, and the aborted routine must show exactly five steps with no completion.

// File: rtl/assist_pkg.sv
package assist_pkg;
  typedef enum logic [1:0] {
    SEL_IDLE = 2'd0,
    SEL_MAIN = 2'd1,
    SEL_HP   = 2'd2,
    SEL_LP   = 2'd3
  } issue_sel_e;
endpackage

// File: rtl/assist_hp_fifo.sv
module assist_hp_fifo #(
  parameter int DEPTH = 4,
  parameter int W     = 2,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  dout,
  output logic          full,
  output logic          empty,
  output logic [CW-1:0] count
);
  logic [W-1:0]  slots [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] cnt;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) slots[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (push) wr_ptr <= bump(wr_ptr);
      if (pop)  rd_ptr <= bump(rd_ptr);
      cnt <= cnt + CW'(push) - CW'(pop);
    end
  end

  assign dout  = slots[rd_ptr];
  assign full  = (cnt == CW'(DEPTH));
  assign empty = (cnt == '0);
  assign count = cnt;

  // R8: the producer never pushes into a full queue
  a_r8_no_overflow: assert property (@(posedge clk) disable iff (rst)
    push |-> (cnt < CW'(DEPTH)));
  // R2: a routine is only started from a non-empty queue
  a_r2_no_underflow: assert property (@(posedge clk) disable iff (rst)
    pop |-> (cnt != '0));
endmodule

// File: rtl/assist_routine_store.sv
module assist_routine_store #(
  parameter int INSTR_W = 16,
  parameter int RID_W   = 2,
  parameter int IDX_W   = 3,
  localparam int AW     = RID_W + IDX_W,
  localparam int ENTRIES = 1 << AW
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               we,
  input  logic [AW-1:0]      wr_addr,
  input  logic [INSTR_W-1:0] wr_data,
  input  logic               wr_last,
  input  logic [AW-1:0]      rd_addr,
  output logic [INSTR_W-1:0] rd_data,
  output logic               rd_last
);
  logic [INSTR_W-1:0] words [ENTRIES];
  logic [ENTRIES-1:0] end_mask;

  // Block-RAM style: one write port, one registered read port
  always_ff @(posedge clk) begin
    if (we) words[wr_addr] <= wr_data;
    rd_data <= words[rd_addr];
  end

  // End marks stay in flops: the sequencer needs them in the issuing cycle
  always_ff @(posedge clk) begin
    if (rst)     end_mask <= '0;
    else if (we) end_mask[wr_addr] <= wr_last;
  end

  assign rd_last = end_mask[rd_addr];
endmodule

// File: rtl/assist_sched.sv
module assist_sched
  import assist_pkg::*;
#(
  parameter int NUM_ROUTINES = 4,
  parameter int ROUTINE_LEN  = 8,
  parameter int INSTR_W      = 16,
  parameter int HQ_DEPTH     = 4,
  localparam int RID_W = (NUM_ROUTINES > 1) ? $clog2(NUM_ROUTINES) : 1,
  localparam int IDX_W = (ROUTINE_LEN > 1) ? $clog2(ROUTINE_LEN) : 1,
  localparam int CNT_W = $clog2(HQ_DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               prog_we,
  input  logic [RID_W-1:0]   prog_rid,
  input  logic [IDX_W-1:0]   prog_idx,
  input  logic [INSTR_W-1:0] prog_instr,
  input  logic               prog_last,
  input  logic               ld_valid,
  input  logic               ld_cmp,
  input  logic [RID_W-1:0]   ld_rid,
  output logic               ld_ready,
  input  logic               st_valid,
  input  logic [RID_W-1:0]   st_rid,
  input  logic               data_arr,
  input  logic               main_req,
  input  logic               slot_gnt,
  output logic [1:0]         iss_sel,
  output logic [RID_W-1:0]   iss_rid,
  output logic [INSTR_W-1:0] iss_instr,
  output logic               done_valid,
  output logic               done_hp,
  output logic [RID_W-1:0]   done_rid
);
  // urgent queue
  logic             f_push, f_pop, f_full, f_empty;
  logic [RID_W-1:0] f_dout;
  logic [CNT_W-1:0] f_count;

  // sequencer state
  logic             hp_act, lp_act, lp_pend;
  logic [RID_W-1:0] hp_rid, lp_rid, lp_pend_rid;
  logic [IDX_W-1:0] hp_pc, lp_pc;
  logic [CNT_W-1:0] arr_cnt;

  // per-cycle decisions
  issue_sel_e       sel;
  logic             hp_start, lp_start, arr_acc;
  logic             issue_hp, issue_lp, end_now, st_last;
  logic [RID_W-1:0] rd_rid;
  logic [IDX_W-1:0] rd_pc;

  // registered outputs
  logic [1:0]       sel_q;
  logic [RID_W-1:0] rid_q, done_rid_q;
  logic             done_q, done_hp_q;

  assign f_push   = ld_valid && ld_cmp && !f_full;
  assign ld_ready = !f_full;
  assign arr_acc  = data_arr && (arr_cnt < f_count);
  assign hp_start = !hp_act && (arr_cnt != '0);
  assign f_pop    = hp_start;
  assign lp_start = lp_pend && !lp_act && !hp_act && f_empty && !f_push;

  always_comb begin
    if (!slot_gnt)     sel = SEL_IDLE;
    else if (hp_act)   sel = SEL_HP;
    else if (main_req) sel = SEL_MAIN;
    else if (lp_act)   sel = SEL_LP;
    else               sel = SEL_IDLE;
  end

  assign issue_hp = (sel == SEL_HP);
  assign issue_lp = (sel == SEL_LP);
  assign rd_rid   = issue_lp ? lp_rid : hp_rid;
  assign rd_pc    = issue_lp ? lp_pc  : hp_pc;
  assign end_now  = st_last || (rd_pc == IDX_W'(ROUTINE_LEN - 1));

  assist_hp_fifo #(.DEPTH(HQ_DEPTH), .W(RID_W)) u_hq (
    .clk(clk), .rst(rst), .push(f_push), .din(ld_rid), .pop(f_pop),
    .dout(f_dout), .full(f_full), .empty(f_empty), .count(f_count)
  );

  assist_routine_store #(.INSTR_W(INSTR_W), .RID_W(RID_W), .IDX_W(IDX_W)) u_store (
    .clk(clk), .rst(rst), .we(prog_we), .wr_addr({prog_rid, prog_idx}),
    .wr_data(prog_instr), .wr_last(prog_last), .rd_addr({rd_rid, rd_pc}),
    .rd_data(iss_instr), .rd_last(st_last)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      hp_act      <= 1'b0;
      hp_rid      <= '0;
      hp_pc       <= '0;
      lp_act      <= 1'b0;
      lp_rid      <= '0;
      lp_pc       <= '0;
      lp_pend     <= 1'b0;
      lp_pend_rid <= '0;
      arr_cnt     <= '0;
      sel_q       <= SEL_IDLE;
      rid_q       <= '0;
      done_q      <= 1'b0;
      done_hp_q   <= 1'b0;
      done_rid_q  <= '0;
    end else begin
      // urgent routine
      if (hp_start) begin
        hp_act <= 1'b1;
        hp_rid <= f_dout;
        hp_pc  <= '0;
      end else if (issue_hp) begin
        if (end_now) hp_act <= 1'b0;
        else         hp_pc  <= hp_pc + 1'b1;
      end
      // optional routine: an urgent start abandons it
      if (hp_start) begin
        lp_act <= 1'b0;
      end else if (lp_start) begin
        lp_act <= 1'b1;
        lp_rid <= lp_pend_rid;
        lp_pc  <= '0;
      end else if (issue_lp) begin
        if (end_now) lp_act <= 1'b0;
        else         lp_pc  <= lp_pc + 1'b1;
      end
      // pending optional request: an accepted urgent request wins
      if (f_push) begin
        lp_pend <= 1'b0;
      end else if (st_valid) begin
        lp_pend     <= 1'b1;
        lp_pend_rid <= st_rid;
      end else if (lp_start) begin
        lp_pend <= 1'b0;
      end
      arr_cnt <= arr_cnt + CNT_W'(arr_acc) - CNT_W'(hp_start);
      // outputs
      sel_q      <= sel;
      rid_q      <= rd_rid;
      done_q     <= (issue_hp || issue_lp) && end_now;
      done_hp_q  <= issue_hp;
      done_rid_q <= rd_rid;
    end
  end

  assign iss_sel    = sel_q;
  assign iss_rid    = rid_q;
  assign done_valid = done_q;
  assign done_hp    = done_hp_q;
  assign done_rid   = done_rid_q;

  // R4: the main stream only got the slot when no urgent routine was running
  a_r4_main_held: assert property (@(posedge clk) disable iff (rst)
    (sel_q == SEL_MAIN) |-> $past(!hp_act));
  // R5: an optional step only used a granted slot the main stream left free
  a_r5_lp_spare_slot: assert property (@(posedge clk) disable iff (rst)
    (sel_q == SEL_LP) |-> $past(!main_req && slot_gnt));
  // R7: optional and urgent routines never run together
  a_r7_lp_yields: assert property (@(posedge clk) disable iff (rst)
    hp_act |-> !lp_act);
  // R2: arrival credits never exceed queued loads
  a_r2_credit_bound: assert property (@(posedge clk) disable iff (rst)
    arr_cnt <= f_count);
  // R9: completion only accompanies a routine step
  a_r9_done_with_step: assert property (@(posedge clk) disable iff (rst)
    done_q |-> (sel_q == SEL_HP || sel_q == SEL_LP));
  // R10: no slot, no issue
  a_r10_idle_no_grant: assert property (@(posedge clk) disable iff (rst)
    !$past(slot_gnt) |-> (sel_q == SEL_IDLE));
endmodule

// File: tb/tb_assist_sched.sv
module tb_assist_sched;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic        prog_we = 0, prog_last = 0;
  logic [1:0]  prog_rid = 0;
  logic [2:0]  prog_idx = 0;
  logic [15:0] prog_instr = 0;
  logic        ld_valid = 0, ld_cmp = 0, st_valid = 0, data_arr = 0;
  logic [1:0]  ld_rid = 0, st_rid = 0;
  logic        main_req = 0, slot_gnt = 0;
  logic        ld_ready;
  logic [1:0]  iss_sel, iss_rid, done_rid;
  logic [15:0] iss_instr;
  logic        done_valid, done_hp;

  always #(CLK_PERIOD/2) clk = ~clk;

  assist_sched dut (
    .clk(clk), .rst(rst), .prog_we(prog_we), .prog_rid(prog_rid), .prog_idx(prog_idx),
    .prog_instr(prog_instr), .prog_last(prog_last), .ld_valid(ld_valid), .ld_cmp(ld_cmp),
    .ld_rid(ld_rid), .ld_ready(ld_ready), .st_valid(st_valid), .st_rid(st_rid),
    .data_arr(data_arr), .main_req(main_req), .slot_gnt(slot_gnt), .iss_sel(iss_sel),
    .iss_rid(iss_rid), .iss_instr(iss_instr), .done_valid(done_valid), .done_hp(done_hp),
    .done_rid(done_rid)
  );

  typedef struct packed {
    logic [1:0]  sel;
    logic [1:0]  rid;
    logic [15:0] instr;
    logic        done;
  } item_t;

  item_t exp_q[$];
  int n_chk = 0, n_fail = 0;
  int hp_seen = 0, lp_seen = 0;
  bit hp_running = 0, run_mon = 0, finished = 0;
  logic gnt_prev = 0, mreq_prev = 0;

  function automatic logic [15:0] word_of(int r, int k);
    return 16'hA000 ^ (16'(r) << 8) ^ (16'(k) * 16'd17);
  endfunction
  function automatic int len_of(int r);
    return (r == 3) ? 8 : r + 2;
  endfunction

  task automatic check_eq(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic expect_run(logic [1:0] s, int r, int n, bit completes);
    for (int k = 0; k < n; k++) begin
      item_t it;
      it.sel = s; it.rid = 2'(r); it.instr = word_of(r, k);
      it.done = completes && (k == n - 1);
      exp_q.push_back(it);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wait_drain();
    int guard = 0;
    while ((exp_q.size() != 0 || hp_running) && guard < 400) begin
      tick(); guard++;
    end
    check_eq("R1 expected steps all issued", exp_q.size(), 0);
  endtask

  always @(posedge clk) begin
    gnt_prev  <= slot_gnt;
    mreq_prev <= main_req;
  end

  // monitor / scoreboard
  always @(negedge clk) begin
    if (!rst && run_mon) begin
      if (!gnt_prev) check_eq("R10 idle after withheld grant", iss_sel, 0);
      if (iss_sel == 2'd1) check_eq("R4 main issued inside urgent routine", int'(hp_running), 0);
      if (iss_sel == 2'd3) check_eq("R5 optional step with main request", int'(mreq_prev), 0);
      if (done_valid && iss_sel < 2'd2) check_eq("R9 done without routine step", 1, 0);
      if (iss_sel >= 2'd2) begin
        if (iss_sel == 2'd2) hp_seen++; else lp_seen++;
        if (exp_q.size() == 0) begin
          check_eq("R1 unexpected routine step sel", iss_sel, 0);
        end else begin
          item_t it;
          it = exp_q.pop_front();
          check_eq("R11 step owner", iss_sel, it.sel);
          check_eq("R2 routine number", iss_rid, it.rid);
          check_eq("R1 instruction word", iss_instr, it.instr);
          check_eq("R9 completion flag", done_valid, it.done);
          if (it.done) begin
            check_eq("R9 completion priority", done_hp, it.sel == 2'd2);
            check_eq("R9 completion routine", done_rid, it.rid);
          end
        end
        if (iss_sel == 2'd2) hp_running = !done_valid;
      end
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int base;
    rst = 1'b1;
    repeat (3) tick();
    // R12 reset state
    check_eq("R12 iss_sel in reset", iss_sel, 0);
    check_eq("R12 done_valid in reset", done_valid, 0);
    check_eq("R12 ld_ready in reset", ld_ready, 1);
    rst = 1'b0;
    tick();
    check_eq("R12 iss_sel after reset", iss_sel, 0);

    // load routines: r0..r2 end-marked, r3 runs to the last index
    for (int r = 0; r < 4; r++) begin
      for (int k = 0; k < len_of(r); k++) begin
        prog_we = 1; prog_rid = 2'(r); prog_idx = 3'(k);
        prog_instr = word_of(r, k);
        prog_last = (r != 3) && (k == len_of(r) - 1);
        tick();
      end
    end
    prog_we = 0; prog_last = 0;
    slot_gnt = 1;
    tick();
    run_mon = 1;

    // R3: uncompressed load, then a stray arrival
    base = hp_seen;
    ld_valid = 1; ld_cmp = 0; ld_rid = 2; tick();
    ld_valid = 0; data_arr = 1; tick();
    data_arr = 0;
    repeat (10) tick();
    check_eq("R3 no routine from plain load", hp_seen, base);

    // R2/R4: compressed load waits for arrival, then takes the slot
    main_req = 1;
    ld_valid = 1; ld_cmp = 1; ld_rid = 1; tick();
    ld_valid = 0;
    repeat (5) tick();
    check_eq("R2 no start before arrival", iss_sel, 1);
    check_eq("R2 no urgent step before arrival", hp_seen, base);
    expect_run(2'd2, 1, 3, 1);
    data_arr = 1; tick();
    data_arr = 0;
    for (int i = 0; i < 6; i++) begin
      slot_gnt = i[0]; tick();
    end
    slot_gnt = 1;
    wait_drain();
    tick(); tick();
    check_eq("R4 main resumes after urgent routine", iss_sel, 1);

    // R5: optional routine waits for spare slots
    base = lp_seen;
    st_valid = 1; st_rid = 2; tick();
    st_valid = 0;
    repeat (8) tick();
    check_eq("R5 optional held while main requests", lp_seen, base);
    expect_run(2'd3, 2, 4, 1);
    for (int i = 0; i < 10; i++) begin
      main_req = i[0]; tick();
    end
    main_req = 0;
    wait_drain();

    // R6: pending optional dropped by a later urgent request
    base = lp_seen;
    main_req = 1;
    st_valid = 1; st_rid = 3; tick();
    st_valid = 0;
    expect_run(2'd2, 0, 2, 1);
    ld_valid = 1; ld_cmp = 1; ld_rid = 0; tick();
    ld_valid = 0; data_arr = 1; tick();
    data_arr = 0; main_req = 0;
    wait_drain();
    repeat (12) tick();
    check_eq("R6 dropped optional never issues", lp_seen, base);

    // R6: store and urgent request on the same edge
    expect_run(2'd2, 0, 2, 1);
    st_valid = 1; st_rid = 2; ld_valid = 1; ld_cmp = 1; ld_rid = 0; tick();
    st_valid = 0; ld_valid = 0; data_arr = 1; tick();
    data_arr = 0;
    wait_drain();
    repeat (12) tick();
    check_eq("R6 same-cycle store discarded", lp_seen, base);

    // R7: urgent start abandons a running optional routine after 5 steps
    base = lp_seen;
    expect_run(2'd3, 3, 5, 0);
    expect_run(2'd2, 1, 3, 1);
    st_valid = 1; st_rid = 3; tick();
    st_valid = 0;
    repeat (3) tick();
    ld_valid = 1; ld_cmp = 1; ld_rid = 1; tick();
    ld_valid = 0; data_arr = 1; tick();
    data_arr = 0;
    wait_drain();
    repeat (12) tick();
    check_eq("R7 aborted optional step count", lp_seen - base, 5);

    // R8: queue fills, extra load ignored; R2: extra arrival ignored, order kept
    for (int r = 0; r < 4; r++) expect_run(2'd2, r, len_of(r), 1);
    for (int r = 0; r < 4; r++) begin
      ld_valid = 1; ld_cmp = 1; ld_rid = 2'(r); tick();
    end
    ld_valid = 0;
    check_eq("R8 ld_ready low when full", ld_ready, 0);
    ld_valid = 1; ld_rid = 2; tick();
    ld_valid = 0;
    check_eq("R8 still full after refused load", ld_ready, 0);
    for (int i = 0; i < 5; i++) begin
      data_arr = 1; tick();
    end
    data_arr = 0;
    wait_drain();
    repeat (20) tick();
    check_eq("R8 ld_ready back after drain", ld_ready, 1);
    check_eq("R8 no extra routine left", exp_q.size(), 0);

    finish_run();
  end
endmodule